// File: doc/BRIEF.md
# CF Task-File Window Decoder

This block sits between the host side of a removable-card storage interface and an ATA register core. It takes host read and write cycles, picks one of four address windows from a two-bit mode input, and turns a decoded access into a register index within a 16-entry task file. Most accesses go straight through to the ATA core on a simple register port. Alternate status, the device-address byte and the device-control register are handled inside the block and do not reach the core.

Hosts with an 8-bit data path can still move 16-bit data words. A phase flag and a one-byte holding register split every word into two byte cycles. For writes, the first byte is held and the word goes out on the second cycle. For reads, the word is fetched on the first cycle and its high byte is held for the second. A write to an ordinary register while the card is powered down also raises a wake pulse, so the surrounding logic can restore card-ready.

Top module: `cf_taskfile_decoder`

## Requirements
- R1: With mode = 0, only addresses 0x400 to 0x7FF are decoded, and the register index is host_addr[3:0]. Any other address is ignored.
- R2: With mode = 1, every address is decoded, and the register index is host_addr[3:0].
- R3: Mode = 2 uses base addresses 0x1F0 (lower) and 0x3F0 (upper). Mode = 3 uses 0x170 (lower) and 0x370 (upper). Lower offsets 0 to 7 map to indices 0 to 7. Upper offset 6 maps to index 0xE and upper offset 7 to index 0xF. Every other address is ignored: no core strobe is raised and a read returns 0.
- R4: A read result appears on host_rdata after the clock edge that samples the read strobe, and it is held until the next read. A 16-bit access (host_wide = 1) to index 0 passes the whole word to or from the core at core index 0.
- R5: An 8-bit write to index 0 with the phase clear only holds the low byte and sets the phase. The next such write raises ata_wr at core index 0 with data {new byte, held byte} and clears the phase.
- R6: An 8-bit read of index 0 with the phase clear raises ata_rd, returns the low byte of the core word (upper byte 0) and holds the high byte. The next byte read raises no ata_rd and returns the held byte.
- R7: Index 9 is always accessed bytewise, whatever host_wide is. It shares the phase flag and the held byte with index 0, and uses core index 0.
- R8: Index 0xD is forwarded to core index 1 for both reads and writes.
- R9: A read of index 0xE returns ata_status in the low byte and raises no ata_rd.
- R10: A write to index 0xE loads devctl at the next edge and raises no ata_wr. If bit 2 of the written byte is set, srst_req pulses high for one cycle.
- R11: A read of index 0xF returns 0xC2 | (~ata_sel << 2), with ata_sel 4 bits wide, and raises no ata_rd.
- R12: A write to any index other than 0, 9, 0xD and 0xE is forwarded to the core at that same index. If pwrdn_in is high, wake pulses high for one cycle after that write. Writes to 0, 9, 0xD and 0xE never raise wake.
- R13: Reset clears the phase flag, the held byte, host_rdata, devctl, srst_req and wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Address window select (0 to 3) |
| host_addr | input | 11 | Host address |
| host_wdata | input | 16 | Host write data |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access; takes precedence over host_rd |
| host_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| host_rdata | output | 16 | Registered read result |
| ata_idx | output | 4 | Core register index |
| ata_rd | output | 1 | Core read strobe |
| ata_wr | output | 1 | Core write strobe |
| ata_wdata | output | 16 | Core write data |
| ata_rdata | input | 16 | Core read data, same cycle as ata_rd |
| ata_status | input | 8 | Core status byte, read without side effects |
| ata_sel | input | 4 | Drive-select bits from the core |
| pwrdn_in | input | 1 | Card is in power-down |
| devctl | output | 8 | Device-control register |
| srst_req | output | 1 | Soft-reset request pulse |
| wake | output | 1 | Power-down exit pulse |

## Verification
The core-side strobes, index and write data are combinational, so they are due in the same cycle as the host strobe. The bench samples them 1 ns after it drives inputs on the falling edge. host_rdata, devctl, srst_req and wake change at the rising edge that samples the strobe, and the bench checks them 1 ns after that edge. The one-cycle width of the pulses is checked after one further idle edge. Byte-pairing cases are run in sequence, so that every check sees a known phase.

// File: rtl/cf_taskfile_decoder.sv
module cf_taskfile_decoder #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic          host_wide,
  output logic [DW-1:0] host_rdata,
  output logic [3:0]    ata_idx,
  output logic          ata_rd,
  output logic          ata_wr,
  output logic [DW-1:0] ata_wdata,
  input  logic [DW-1:0] ata_rdata,
  input  logic [DW/2-1:0] ata_status,
  input  logic [3:0]    ata_sel,
  input  logic          pwrdn_in,
  output logic [DW/2-1:0] devctl,
  output logic          srst_req,
  output logic          wake
);
  localparam int BW = DW / 2;
  localparam logic [AW-1:0] MEM_BASE = AW'('h400);
  localparam logic [AW-1:0] PRI_LO   = AW'('h1F0);
  localparam logic [AW-1:0] PRI_HI   = AW'('h3F0);
  localparam logic [AW-1:0] SEC_LO   = AW'('h170);
  localparam logic [AW-1:0] SEC_HI   = AW'('h370);
  localparam logic [3:0] IX_DATA = 4'h0, IX_ODD = 4'h9, IX_FEAT = 4'hD,
                         IX_CTRL = 4'hE, IX_DADR = 4'hF;

  logic          hit;
  logic [3:0]    idx;
  logic [AW-1:0] lo_base, hi_base;
  logic          phase;
  logic [BW-1:0] hold;

  assign lo_base = (mode == 2'd2) ? PRI_LO : SEC_LO;
  assign hi_base = (mode == 2'd2) ? PRI_HI : SEC_HI;

  always_comb begin
    hit = 1'b0;
    idx = host_addr[3:0];
    case (mode)
      2'd0: hit = (host_addr[AW-1:10] == MEM_BASE[AW-1:10]);
      2'd1: hit = 1'b1;
      default: begin
        if (host_addr[AW-1:4] == lo_base[AW-1:4] && !host_addr[3]) begin
          hit = 1'b1;
          idx = {1'b0, host_addr[2:0]};
        end else if (host_addr[AW-1:4] == hi_base[AW-1:4] && host_addr[3:1] == 3'b011) begin
          hit = 1'b1;
          idx = {3'b111, host_addr[0]};
        end
      end
    endcase
  end

  logic acc_rd, acc_wr, is_data, bytewise;
  assign acc_wr   = host_wr & hit;
  assign acc_rd   = host_rd & ~host_wr & hit;
  assign is_data  = (idx == IX_DATA) || (idx == IX_ODD);
  assign bytewise = (idx == IX_ODD) || !host_wide;

  assign ata_idx   = is_data ? IX_DATA : (idx == IX_FEAT) ? 4'h1 : idx;
  assign ata_wr    = acc_wr & (is_data ? (!bytewise || phase) : (idx != IX_CTRL));
  assign ata_rd    = acc_rd & (is_data ? (!bytewise || !phase)
                                       : (idx != IX_CTRL && idx != IX_DADR));
  assign ata_wdata = (is_data && bytewise) ? {host_wdata[BW-1:0], hold} : host_wdata;

  logic [DW-1:0] rd_next;
  always_comb begin
    if (is_data && bytewise)
      rd_next = {{BW{1'b0}}, phase ? hold : ata_rdata[BW-1:0]};
    else if (idx == IX_CTRL)
      rd_next = {{BW{1'b0}}, ata_status};
    else if (idx == IX_DADR)
      rd_next = {{BW{1'b0}}, BW'('hC2) | BW'({~ata_sel, 2'b00})};
    else
      rd_next = ata_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
      phase      <= 1'b0;
      hold       <= '0;
      devctl     <= '0;
      srst_req   <= 1'b0;
      wake       <= 1'b0;
    end else begin
      if (host_rd && !host_wr) host_rdata <= hit ? rd_next : '0;
      if ((acc_rd || acc_wr) && is_data && bytewise) begin
        phase <= !phase;
        if (!phase) hold <= acc_wr ? host_wdata[BW-1:0] : ata_rdata[DW-1:BW];
      end
      if (acc_wr && idx == IX_CTRL) devctl <= host_wdata[BW-1:0];
      srst_req <= acc_wr && idx == IX_CTRL && host_wdata[2];
      wake     <= acc_wr && !is_data && idx != IX_FEAT && idx != IX_CTRL && pwrdn_in;
    end
  end

  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ata_rd && ata_wr));

  a_r3_outside_windows_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_rd || host_wr) && mode == 2'd2 &&
     host_addr[AW-1:4] != PRI_LO[AW-1:4] && host_addr[AW-1:4] != PRI_HI[AW-1:4])
    |-> (!ata_rd && !ata_wr));

  a_r9_alt_status_no_core_read: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && idx == IX_CTRL) |-> !ata_rd);

  a_r6_second_byte_local: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && is_data && bytewise && phase) |-> !ata_rd);

  a_r10_soft_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && idx == IX_CTRL && host_wdata[2]) |=> (srst_req && devctl[2]));

  a_r12_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> ($past(pwrdn_in) && $past(ata_wr)));
endmodule

// File: tb/cf_taskfile_decoder_test.sv
`timescale 1ns/1ps
module cf_taskfile_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = '0;
  logic [10:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic host_rd = 1'b0, host_wr = 1'b0, host_wide = 1'b1;
  logic [15:0] host_rdata;
  logic [3:0] ata_idx;
  logic ata_rd, ata_wr;
  logic [15:0] ata_wdata;
  logic [15:0] ata_rdata = '0;
  logic [7:0] ata_status = 8'h50;
  logic [3:0] ata_sel = 4'hA;
  logic pwrdn_in = 1'b0;
  logic [7:0] devctl;
  logic srst_req, wake;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cf_taskfile_decoder uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_wr(host_wr),
    .host_wide(host_wide), .host_rdata(host_rdata), .ata_idx(ata_idx),
    .ata_rd(ata_rd), .ata_wr(ata_wr), .ata_wdata(ata_wdata),
    .ata_rdata(ata_rdata), .ata_status(ata_status), .ata_sel(ata_sel),
    .pwrdn_in(pwrdn_in), .devctl(devctl), .srst_req(srst_req), .wake(wake)
  );

  // mode, addr, op(1 rd,2 wr), wide, wdata, core rdata, expected strobe(0,1 rd,2 wr), idx, wdata, rdata
  localparam int NV = 26;
  localparam logic [85:0] VEC [NV] = '{
    {2'd0, 11'h400, 2'd1, 1'b1, 16'h0000, 16'h1234, 2'd1, 4'h0, 16'h0000, 16'h1234},
    {2'd0, 11'h3F0, 2'd1, 1'b1, 16'h0000, 16'h7777, 2'd0, 4'h0, 16'h0000, 16'h0000},
    {2'd0, 11'h40D, 2'd2, 1'b1, 16'h00AB, 16'h0000, 2'd2, 4'h1, 16'h00AB, 16'h0000},
    {2'd1, 11'h007, 2'd1, 1'b1, 16'h0000, 16'h0058, 2'd1, 4'h7, 16'h0000, 16'h0058},
    {2'd1, 11'h7F3, 2'd2, 1'b1, 16'h0011, 16'h0000, 2'd2, 4'h3, 16'h0011, 16'h0000},
    {2'd2, 11'h1F2, 2'd2, 1'b1, 16'h0005, 16'h0000, 2'd2, 4'h2, 16'h0005, 16'h0000},
    {2'd2, 11'h3F6, 2'd1, 1'b1, 16'h0000, 16'h9999, 2'd0, 4'h0, 16'h0000, 16'h0050},
    {2'd2, 11'h3F7, 2'd1, 1'b1, 16'h0000, 16'h9999, 2'd0, 4'h0, 16'h0000, 16'h00D6},
    {2'd2, 11'h170, 2'd1, 1'b1, 16'h0000, 16'h9999, 2'd0, 4'h0, 16'h0000, 16'h0000},
    {2'd2, 11'h1F8, 2'd1, 1'b1, 16'h0000, 16'h9999, 2'd0, 4'h0, 16'h0000, 16'h0000},
    {2'd2, 11'h3F2, 2'd2, 1'b1, 16'h0042, 16'h0000, 2'd0, 4'h0, 16'h0000, 16'h0000},
    {2'd3, 11'h177, 2'd1, 1'b1, 16'h0000, 16'h00C0, 2'd1, 4'h7, 16'h0000, 16'h00C0},
    {2'd3, 11'h376, 2'd1, 1'b1, 16'h0000, 16'h9999, 2'd0, 4'h0, 16'h0000, 16'h0050},
    {2'd3, 11'h1F0, 2'd1, 1'b1, 16'h0000, 16'h9999, 2'd0, 4'h0, 16'h0000, 16'h0000},
    {2'd3, 11'h171, 2'd1, 1'b1, 16'h0000, 16'h0004, 2'd1, 4'h1, 16'h0000, 16'h0004},
    {2'd1, 11'h000, 2'd2, 1'b0, 16'h00CD, 16'h0000, 2'd0, 4'h0, 16'h0000, 16'h0000},
    {2'd1, 11'h000, 2'd2, 1'b0, 16'h00EF, 16'h0000, 2'd2, 4'h0, 16'hEFCD, 16'h0000},
    {2'd1, 11'h000, 2'd1, 1'b0, 16'h0000, 16'hA55A, 2'd1, 4'h0, 16'h0000, 16'h005A},
    {2'd1, 11'h000, 2'd1, 1'b0, 16'h0000, 16'h1111, 2'd0, 4'h0, 16'h0000, 16'h00A5},
    {2'd1, 11'h009, 2'd1, 1'b1, 16'h0000, 16'hBEEF, 2'd1, 4'h0, 16'h0000, 16'h00EF},
    {2'd1, 11'h009, 2'd1, 1'b1, 16'h0000, 16'h2222, 2'd0, 4'h0, 16'h0000, 16'h00BE},
    {2'd1, 11'h000, 2'd2, 1'b0, 16'h0012, 16'h0000, 2'd0, 4'h0, 16'h0000, 16'h0000},
    {2'd1, 11'h009, 2'd2, 1'b1, 16'h0034, 16'h0000, 2'd2, 4'h0, 16'h3412, 16'h0000},
    {2'd1, 11'h00D, 2'd1, 1'b1, 16'h0000, 16'h0004, 2'd1, 4'h1, 16'h0000, 16'h0004},
    {2'd1, 11'h00D, 2'd2, 1'b1, 16'h0003, 16'h0000, 2'd2, 4'h1, 16'h0003, 16'h0000},
    {2'd1, 11'h00E, 2'd2, 1'b1, 16'h0002, 16'h0000, 2'd0, 4'h0, 16'h0000, 16'h0000}
  };
  string req_of [NV] = '{"R4", "R1", "R1", "R2", "R2", "R3", "R9", "R11", "R3", "R3",
                         "R3", "R3", "R9", "R3", "R3", "R5", "R5", "R6", "R6", "R7",
                         "R7", "R7", "R7", "R8", "R8", "R10"};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic [10:0] a, input logic [1:0] op,
                       input logic w, input logic [15:0] wd, input logic [15:0] crd);
    mode = m; host_addr = a; host_wide = w; host_wdata = wd; ata_rdata = crd;
    host_rd = (op == 2'd1); host_wr = (op == 2'd2);
  endtask

  task automatic release_bus();
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0;
  endtask

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    // R13: reset state
    check(host_rdata == 16'h0 && devctl == 8'h0 && !srst_req && !wake, "R13", "reset outputs",
          {devctl, 6'b0, srst_req, wake}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [85:0] v;
      v = VEC[i];
      drive(v[85:84], v[83:73], v[72:71], v[70], v[69:54], v[53:38]);
      #1;
      check(ata_rd == (v[37:36] == 2'd1) && ata_wr == (v[37:36] == 2'd2), req_of[i],
            $sformatf("strobes vec %0d", i), {14'b0, ata_wr, ata_rd},
            {14'b0, v[37:36] == 2'd2, v[37:36] == 2'd1});
      if (v[37:36] != 2'd0)
        check(ata_idx == v[35:32], req_of[i], $sformatf("core index vec %0d", i),
              {12'b0, ata_idx}, {12'b0, v[35:32]});
      if (v[37:36] == 2'd2)
        check(ata_wdata == v[31:16], req_of[i], $sformatf("core wdata vec %0d", i),
              ata_wdata, v[31:16]);
      @(posedge clk);
      #1;
      if (v[72:71] == 2'd1)
        check(host_rdata == v[15:0], req_of[i], $sformatf("read data vec %0d", i),
              host_rdata, v[15:0]);
      release_bus();
    end

    // R10: last vector wrote 0x02 to device control, no soft reset
    #1;
    check(devctl == 8'h02 && !srst_req, "R10", "devctl load without reset",
          {devctl, 7'b0, srst_req}, 16'h0200);

    // R10: soft-reset bit pulses srst_req for one cycle
    drive(2'd1, 11'h00E, 2'd2, 1'b1, 16'h0004, 16'h0);
    #1;
    check(!ata_wr, "R10", "devctl write not forwarded", {15'b0, ata_wr}, 16'h0);
    @(posedge clk); #1;
    check(srst_req && devctl == 8'h04, "R10", "srst pulse high",
          {devctl, 7'b0, srst_req}, 16'h0401);
    release_bus();
    @(posedge clk); #1;
    check(!srst_req, "R10", "srst pulse ends", {15'b0, srst_req}, 16'h0);
    @(negedge clk);

    // R12: forwarded write during power-down raises wake
    pwrdn_in = 1'b1;
    drive(2'd1, 11'h003, 2'd2, 1'b1, 16'h0033, 16'h0);
    #1;
    check(ata_wr && ata_idx == 4'h3, "R12", "forwarded write", {11'b0, ata_wr, ata_idx}, 16'h0013);
    @(posedge clk); #1;
    check(wake, "R12", "wake pulse", {15'b0, wake}, 16'h1);
    release_bus();
    @(posedge clk); #1;
    check(!wake, "R12", "wake pulse ends", {15'b0, wake}, 16'h0);
    @(negedge clk);
    // R12: device-control and data writes never wake
    drive(2'd1, 11'h00E, 2'd2, 1'b1, 16'h0000, 16'h0);
    @(posedge clk); #1;
    check(!wake, "R12", "no wake on devctl", {15'b0, wake}, 16'h0);
    release_bus();
    drive(2'd1, 11'h000, 2'd2, 1'b1, 16'h5555, 16'h0);
    @(posedge clk); #1;
    check(!wake, "R12", "no wake on data", {15'b0, wake}, 16'h0);
    release_bus();
    pwrdn_in = 1'b0;

    // R13: reset clears a half-finished byte pair
    drive(2'd1, 11'h000, 2'd2, 1'b0, 16'h0077, 16'h0);
    @(posedge clk);
    release_bus();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(2'd1, 11'h000, 2'd2, 1'b0, 16'h0088, 16'h0);
    #1;
    check(!ata_wr, "R13", "phase cleared by reset", {15'b0, ata_wr}, 16'h0);
    @(posedge clk);
    release_bus();
    drive(2'd1, 11'h000, 2'd2, 1'b0, 16'h0099, 16'h0);
    #1;
    check(ata_wr && ata_wdata == 16'h9988, "R5", "pair after reset", ata_wdata, 16'h9988);
    @(posedge clk);
    release_bus();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule